// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel that sits on a simple synchronous register bus. Software picks a count width (16 or 32 bits), a prescale factor (1, 16 or 256), and a counting mode: free-running, periodic or one-shot. It then writes a start value and enables counting. The counter moves down by one on every prescaled tick. Raw ticks come from a timer-clock enable input. When the counter reaches zero the block sets a raw interrupt flag. The flag is masked by an interrupt-enable bit to drive a level interrupt output, and it stays set until software writes the clear register.

Two registers hold the reload value. The immediate-load register also copies the value into the counter at once. The background-load register only changes what the counter takes at its next wrap. In free-running mode the reload value is ignored, and the counter wraps to all ones of the selected width.

A small state machine tracks whether the counter may run. The states are:
- `ST_IDLE`: counting is disabled.
- `ST_RUN`: the counter moves on prescaled ticks.
- `ST_HALT`: a one-shot count has expired and is parked at zero.

The transitions are:
- START: `ST_IDLE` to `ST_RUN`, on a control write with the enable bit set.
- STOP: `ST_RUN` or `ST_HALT` to `ST_IDLE`, on a control write with the enable bit clear.
- EXPIRE: `ST_RUN` to `ST_HALT`, on expiry in one-shot mode.
- REARM: `ST_HALT` to `ST_RUN`, on a control write with enable set, or on a write to the immediate-load register.

Top module: `interval_timer`

## Requirements
- R1: Registers are selected by word index on `reg_addr`. The mapping is: 0 is immediate load, 1 is current value, 2 is control, 3 is interrupt clear, 4 is raw status, 5 is masked status, 6 is background load. Indices 0 and 6 both read back the stored 32-bit reload value. Indices 3 and 7 read zero.
- R2: The control bits are: bit 7 enables counting, bit 1 selects 32-bit width (clear means 16-bit), and bit 0 selects one-shot. The counter moves down by one only on a prescaled tick, and only while enabled and in `ST_RUN`. A cycle with `tick_en` low never advances the counter. In 32-bit mode, counting crosses the 16-bit boundary (0x00010000 goes to 0x0000FFFF).
- R3: The counter expires on a tick that brings it to zero. That tick sets the raw flag, which reads 1 at index 4. On the next tick the counter reloads. In periodic mode (control bit 6) it reloads from the reload value.
- R4: A write to index 0 stores the reload value and loads the counter in the same cycle. A write to index 6 stores only the reload value, and the counter picks it up at its next wrap.
- R5: With control bit 6 clear (free-running), every wrap reloads all ones of the selected width (0xFFFF or 0xFFFFFFFF). A write to index 0 then also sets the counter to all ones, while the written value is still stored as the reload value.
- R6: Writes to the current-value register (index 1) and to the status registers (indices 4 and 5) change nothing.
- R7: A write of any data to index 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R8: The `irq` output and the masked status at index 5 both equal the raw flag ANDed with control bit 5. While bit 5 is clear, both read 0 and the raw flag is kept.
- R9: After reset the control register reads 0x20, so the interrupt is enabled and counting is disabled. The counter, the reload value and the raw flag all read 0.
- R10: In one-shot mode the counter stops at zero after its first expiry (`ST_HALT`). It stays there until a write to index 0, or a control write with bit 7 set.
- R11: In 16-bit mode only the low 16 bits of the counter and of the reload value take part in counting, in expiry and in the value readback.
- R12: Control bits 3:2 select the prescale. Code 00 divides by 1, 01 by 16, 10 by 256, and 11 by 1. Every control write restarts the prescaler, and no tick happens in the cycle of that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (3) | Register word index |
| reg_we | input | 1 | Write strobe for the register at `reg_addr` |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| tick_en | input | 1 | Raw timer tick qualifier, one per cycle when high |
| irq | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 16-bit narrow mode, and prescale shifts of 4 and 8. With these defaults a full 16-bit free-running wrap takes about 65,000 cycles, which fits in one run. So does the divide-by-256 boundary, where expiry lands on the 256th cycle and not the 255th. A 32-bit wrap cannot be reached, so the 32-bit path is covered by crossing the 16-bit boundary under a large load value. A behavioural model then follows a stretch of random register traffic and random `tick_en` patterns. Along the way it meets cases such as clear-versus-expiry collisions and width changes while running.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    // word indices of the register file
    localparam int IDX_LOAD   = 0;
    localparam int IDX_VALUE  = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_ICLR   = 3;
    localparam int IDX_RAW    = 4;
    localparam int IDX_MASKED = 5;
    localparam int IDX_BGLOAD = 6;

    // control word bit positions
    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_IE       = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_EN       = 7;

    localparam int CTRL_W = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

endpackage

// File: rtl/ivt_regs.sv
`timescale 1ns/1ps
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_val,
    input  logic              expire,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              f_oneshot,
    output logic              f_wide,
    output logic [1:0]        f_pre,
    output logic              f_periodic,
    output logic              f_en,
    output logic [DATA_W-1:0] reload,
    output logic              raw,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              raw_q;
    logic              bg_wr;
    logic              clr_wr;

    // write strobes
    always_comb begin
        load_wr = we && (addr == ADDR_W'(IDX_LOAD));
        ctrl_wr = we && (addr == ADDR_W'(IDX_CTRL));
        bg_wr   = we && (addr == ADDR_W'(IDX_BGLOAD));
        clr_wr  = we && (addr == ADDR_W'(IDX_ICLR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (load_wr || bg_wr) begin
            reload_q <= wdata;
        end
    end

    // expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expire) begin
            raw_q <= 1'b1;
        end else if (clr_wr) begin
            raw_q <= 1'b0;
        end
    end

    always_comb begin
        f_oneshot  = ctrl_q[CB_ONESHOT];
        f_wide     = ctrl_q[CB_WIDE];
        f_pre      = ctrl_q[CB_PRE_LO +: 2];
        f_periodic = ctrl_q[CB_PERIODIC];
        f_en       = ctrl_q[CB_EN];
        reload     = reload_q;
        raw        = raw_q;
        irq        = raw_q && ctrl_q[CB_IE];
    end

    always_comb begin
        case (addr)
            ADDR_W'(IDX_LOAD),
            ADDR_W'(IDX_BGLOAD): rdata = reload_q;
            ADDR_W'(IDX_VALUE):  rdata = cur_val;
            ADDR_W'(IDX_CTRL):   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_W'(IDX_RAW):    rdata = DATA_W'(raw_q);
            ADDR_W'(IDX_MASKED): rdata = DATA_W'(raw_q && ctrl_q[CB_IE]);
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivt_prescale.sv
`timescale 1ns/1ps
module ivt_prescale #(
    parameter int PRE_MID = 4,
    parameter int PRE_HI  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       tick_en,
    input  logic [1:0] code,
    output logic       tick
);

    localparam int PRE_W = PRE_HI;
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << PRE_MID) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << PRE_HI) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        case (code)
            2'b01:   lim = LIM_MID;
            2'b10:   lim = LIM_HI;
            default: lim = '0;
        endcase
    end

    assign at_lim = (pre_q == lim);
    assign tick   = run && !restart && tick_en && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= at_lim ? '0 : pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ivt_fsm.sv
`timescale 1ns/1ps
module ivt_fsm
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_en_bit,
    input  logic       load_wr,
    input  logic       expire,
    input  logic       oneshot,
    output run_state_e state,
    output logic       run
);

    run_state_e state_q;
    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wr_en_bit) state_d = ST_RUN;          // START
            end
            ST_RUN: begin
                if (ctrl_wr)                state_d = wr_en_bit ? ST_RUN : ST_IDLE; // STOP
                else if (expire && oneshot) state_d = ST_HALT;       // EXPIRE
            end
            ST_HALT: begin
                if (ctrl_wr)      state_d = wr_en_bit ? ST_RUN : ST_IDLE;
                else if (load_wr) state_d = ST_RUN;                  // REARM
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state = state_q;
        run   = (state_q == ST_RUN);
    end

endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
module ivt_counter #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reload,
    input  logic              wide,
    input  logic              periodic,
    output logic [DATA_W-1:0] cur_val,
    output logic              expire
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] target;
    logic [DATA_W-1:0] nxt;

    generate
        if (DATA_W > NARROW_W) begin : g_narrow
            assign mask = wide ? {DATA_W{1'b1}}
                               : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_flat
            assign mask = {DATA_W{1'b1}};
        end
    endgenerate

    always_comb begin
        cur_val = cnt_q & mask;
        target  = periodic ? (reload & mask) : mask;
        nxt     = (cur_val == '0) ? target : ((cur_val - DATA_W'(1)) & mask);
        expire  = tick && !load_wr && (nxt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= periodic ? wdata : {DATA_W{1'b1}};
        end else if (tick) begin
            cnt_q <= nxt;
        end
    end

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
    import ivt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 3,
    parameter int PRE_MID  = 4,
    parameter int PRE_HI   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_en,
    output logic              irq
);

    logic              load_wr;
    logic              ctrl_wr;
    logic              f_oneshot;
    logic              f_wide;
    logic [1:0]        f_pre;
    logic              f_periodic;
    logic              f_en;
    logic [DATA_W-1:0] reload;
    logic              raw;
    logic [DATA_W-1:0] cur_val;
    logic              expire;
    logic              tick;
    logic              run;
    run_state_e        state;

    ivt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .cur_val    (cur_val),
        .expire     (expire),
        .load_wr    (load_wr),
        .ctrl_wr    (ctrl_wr),
        .f_oneshot  (f_oneshot),
        .f_wide     (f_wide),
        .f_pre      (f_pre),
        .f_periodic (f_periodic),
        .f_en       (f_en),
        .reload     (reload),
        .raw        (raw),
        .rdata      (reg_rdata),
        .irq        (irq)
    );

    ivt_prescale #(.PRE_MID(PRE_MID), .PRE_HI(PRE_HI)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ctrl_wr),
        .tick_en (tick_en),
        .code    (f_pre),
        .tick    (tick)
    );

    ivt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_en_bit (reg_wdata[CB_EN]),
        .load_wr   (load_wr),
        .expire    (expire),
        .oneshot   (f_oneshot),
        .state     (state),
        .run       (run)
    );

    ivt_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_wr  (load_wr),
        .wdata    (reg_wdata),
        .reload   (reload),
        .wide     (f_wide),
        .periodic (f_periodic),
        .cur_val  (cur_val),
        .expire   (expire)
    );

endmodule

// File: rtl/ivt_chk.sv
`timescale 1ns/1ps
module ivt_chk
    import ivt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tick_en,
    input logic              irq,
    input logic              tick,
    input logic              expire,
    input logic              raw,
    input logic              load_wr,
    input logic              ctrl_wr,
    input logic              f_en,
    input logic              f_ie,
    input logic              f_wide,
    input logic              f_periodic,
    input logic [DATA_W-1:0] cur_val,
    input run_state_e        state
);

    logic [DATA_W-1:0] full_mask;
    logic              clr_wr;
    logic              val_wr;

    assign full_mask = f_wide ? {DATA_W{1'b1}} : DATA_W'({NARROW_W{1'b1}});
    assign clr_wr    = reg_we && (reg_addr == ADDR_W'(IDX_ICLR));
    assign val_wr    = reg_we && (reg_addr == ADDR_W'(IDX_VALUE));

    // R2
    idle_tracks_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) == !f_en);

    // R2
    no_tick_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> !tick);

    // R3
    expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);

    // R7
    clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !raw);

    // R8
    masked_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_ie |-> !irq);

    // R4
    load_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && f_periodic && f_wide) |=> (cur_val == $past(reg_wdata)));

    // R5
    free_load_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && !f_periodic) |=> (cur_val == full_mask));

    // R6
    value_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && state != ST_RUN) |=> $stable(cur_val));

    // R10
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !load_wr && !ctrl_wr) |=> $stable(cur_val));

endmodule

bind interval_timer ivt_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .tick_en    (tick_en),
    .irq        (irq),
    .tick       (tick),
    .expire     (expire),
    .raw        (raw),
    .load_wr    (load_wr),
    .ctrl_wr    (ctrl_wr),
    .f_en       (f_en),
    .f_ie       (reg_rdata[0] | 1'b1 ? u_regs.ctrl_q[5] : 1'b0),
    .f_wide     (f_wide),
    .f_periodic (f_periodic),
    .cur_val    (cur_val),
    .state      (state)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  b_addr = 3'd1;
    logic        b_we = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        b_tick = 1'b1;
    logic        b_irq;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (b_addr),
        .reg_we    (b_we),
        .reg_wdata (b_wdata),
        .reg_rdata (b_rdata),
        .tick_en   (b_tick),
        .irq       (b_irq)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_ctrl;
    logic [31:0] m_reload;
    logic [31:0] m_count;
    bit          m_raw;
    bit          m_halt;
    int          m_pre;

    task automatic model_step();
        logic [31:0] mask;
        logic [31:0] cur;
        logic [31:0] nv;
        int  div;
        bit  running, cw, lw, bw, clw, tk, ex;
        mask    = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        div     = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
        running = m_ctrl[7] && !m_halt;
        cw  = b_we && b_addr == 3'd2;
        lw  = b_we && b_addr == 3'd0;
        bw  = b_we && b_addr == 3'd6;
        clw = b_we && b_addr == 3'd3;
        tk  = 0;
        ex  = 0;
        if (!running || cw) m_pre = 0;
        else if (b_tick) begin
            if (m_pre == div - 1) begin tk = 1; m_pre = 0; end
            else m_pre = m_pre + 1;
        end
        if (lw) m_count = m_ctrl[6] ? b_wdata : 32'hFFFF_FFFF;
        else if (tk) begin
            cur = m_count & mask;
            if (cur == 0) nv = m_ctrl[6] ? (m_reload & mask) : mask;
            else nv = (cur - 1) & mask;
            m_count = nv;
            ex = (nv == 0);
        end
        if (ex && m_ctrl[0]) m_halt = 1;
        if (lw || cw) m_halt = 0;
        if (cw) m_ctrl = b_wdata[7:0];
        if (lw || bw) m_reload = b_wdata;
        if (clw) m_raw = 0;
        if (ex) m_raw = 1;
    endtask

    function automatic logic [31:0] model_rd(logic [2:0] a);
        logic [31:0] mask;
        mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        case (a)
            3'd0, 3'd6: return m_reload;
            3'd1:       return m_count & mask;
            3'd2:       return {24'd0, m_ctrl};
            3'd4:       return {31'd0, m_raw};
            3'd5:       return {31'd0, m_raw & m_ctrl[5]};
            default:    return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0, 3'd6: return "R4";
            3'd1:       return "R2";
            3'd2:       return "R12";
            3'd4:       return "R3";
            3'd5:       return "R8";
            default:    return "R1";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'h20; m_reload = 0; m_count = 0;
            m_raw = 0; m_halt = 0; m_pre = 0;
        end else begin
            model_step();
        end
    end

    always @(posedge clk) begin
        #1;
        if (cmp_on && rst_n && !finished) begin
            chk(tag_of(b_addr), b_rdata, model_rd(b_addr));
            chk("R8", {31'd0, b_irq}, {31'd0, m_raw & m_ctrl[5]});
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wr(logic [2:0] a, logic [31:0] d);
        b_we = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_we = 1'b0; b_addr = 3'd1;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
        b_addr = a;
        #0.1;
        chk(req, b_rdata, exp);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // reset state, R9 and R1
        rd(3'd2, 32'h20, "R9");
        rd(3'd1, 32'h0, "R9");
        rd(3'd4, 32'h0, "R9");
        rd(3'd0, 32'h0, "R9");
        chk("R9", {31'd0, b_irq}, 32'd0);
        rd(3'd3, 32'h0, "R1");
        rd(3'd7, 32'h0, "R1");

        // periodic 32-bit, divide by 1, load 5
        wr(3'd2, 32'h62);
        wr(3'd0, 32'd5);
        wr(3'd2, 32'hE2);
        step(4);
        rd(3'd1, 32'd1, "R2");
        rd(3'd4, 32'd0, "R3");
        step(1);
        rd(3'd1, 32'd0, "R3");
        rd(3'd4, 32'd1, "R3");
        rd(3'd5, 32'd1, "R8");
        chk("R8", {31'd0, b_irq}, 32'd1);
        step(1);
        rd(3'd1, 32'd5, "R3");

        // interrupt masked
        wr(3'd2, 32'hC2);
        rd(3'd4, 32'd1, "R8");
        rd(3'd5, 32'd0, "R8");
        chk("R8", {31'd0, b_irq}, 32'd0);

        // stop, clear, ignored writes
        wr(3'd2, 32'h62);
        wr(3'd3, 32'hDEAD_BEEF);
        rd(3'd4, 32'd0, "R7");
        rd(3'd1, 32'd5, "R6");
        wr(3'd1, 32'h1234);
        rd(3'd1, 32'd5, "R6");
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd1);
        rd(3'd4, 32'd0, "R6");

        // background load
        wr(3'd0, 32'd10);
        wr(3'd6, 32'd3);
        rd(3'd1, 32'd10, "R4");
        rd(3'd0, 32'd3, "R4");
        rd(3'd6, 32'd3, "R4");
        wr(3'd2, 32'hE2);
        step(9);
        rd(3'd1, 32'd1, "R2");
        step(1);
        rd(3'd1, 32'd0, "R3");
        step(1);
        rd(3'd1, 32'd3, "R4");

        // tick_en gating
        b_tick = 1'b0;
        step(5);
        rd(3'd1, 32'd3, "R2");
        b_tick = 1'b1;
        step(1);
        rd(3'd1, 32'd2, "R2");

        // free-running 16-bit full wrap
        wr(3'd2, 32'h00);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd7);
        rd(3'd1, 32'h0000_FFFF, "R5");
        rd(3'd0, 32'd7, "R5");
        wr(3'd2, 32'h80);
        step(65534);
        rd(3'd1, 32'd1, "R5");
        rd(3'd4, 32'd0, "R5");
        step(1);
        rd(3'd1, 32'd0, "R5");
        rd(3'd4, 32'd1, "R3");
        chk("R8", {31'd0, b_irq}, 32'd0);
        step(1);
        rd(3'd1, 32'h0000_FFFF, "R5");

        // 32-bit crosses the 16-bit boundary
        wr(3'd2, 32'h62);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0001_0001);
        rd(3'd1, 32'h0001_0001, "R2");
        wr(3'd2, 32'hE2);
        step(2);
        rd(3'd1, 32'h0000_FFFF, "R2");

        // 16-bit periodic masking
        wr(3'd2, 32'h60);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0005_0003);
        rd(3'd1, 32'd3, "R11");
        rd(3'd0, 32'h0005_0003, "R1");
        wr(3'd2, 32'hE0);
        step(3);
        rd(3'd1, 32'd0, "R11");
        rd(3'd4, 32'd1, "R11");
        step(1);
        rd(3'd1, 32'd3, "R11");

        // prescale 16
        wr(3'd2, 32'h62);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd2);
        wr(3'd2, 32'hE6);
        step(15);
        rd(3'd1, 32'd2, "R12");
        step(1);
        rd(3'd1, 32'd1, "R12");
        step(15);
        rd(3'd4, 32'd0, "R12");
        step(1);
        rd(3'd4, 32'd1, "R12");

        // prescale 256
        wr(3'd2, 32'h62);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'hEA);
        step(255);
        rd(3'd4, 32'd0, "R12");
        step(1);
        rd(3'd4, 32'd1, "R12");

        // prescale code 11 behaves as divide by 1
        wr(3'd2, 32'h62);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'hEE);
        rd(3'd4, 32'd0, "R12");
        step(1);
        rd(3'd4, 32'd1, "R12");

        // one-shot
        wr(3'd2, 32'h63);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd3);
        wr(3'd2, 32'hE3);
        step(3);
        rd(3'd1, 32'd0, "R10");
        rd(3'd4, 32'd1, "R10");
        step(20);
        rd(3'd1, 32'd0, "R10");
        wr(3'd0, 32'd4);
        step(1);
        rd(3'd1, 32'd3, "R10");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            b_tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 7) == 0) begin
                b_we = 1'b1;
                b_addr = 3'($urandom_range(0, 7));
                b_wdata = (b_addr == 3'd2) ? 32'($urandom_range(0, 255))
                                           : 32'($urandom_range(0, 40));
            end else begin
                b_we = 1'b0;
                b_addr = 3'($urandom_range(0, 7));
            end
            @(negedge clk);
        end
        b_we = 1'b0;
        step(2);
        finish_run();
    end

endmodule